// File: doc/BRIEF.md
# SPI Slave with Ready Handshake

This block is a serial slave that takes a block of bytes from a master over an SPI link and hands back a status block. Next to the usual clock, select and data lines it drives a ready line, which sets the pace of the exchange. The master raises an active-high chip select to ask for a cycle. The slave answers by raising ready, and only then may the master shift. After the last bit the master lowers chip select. Ready stays high until the local logic reports that it has processed the received block and has written the status for the next cycle. When ready falls, the master may ask for a new cycle.

The serial clock, select and data inputs are brought into the system clock through two-flop synchronizers, and all edge detection happens in that domain. Clock polarity and phase come from two configuration inputs, so all four SPI modes are available. Every byte is shifted most-significant bit first. The received block and the outgoing status block are flat buses with byte 0 in the top eight bits. A done strobe marks the end of each block and comes with the byte count and an error flag for a truncated byte. A timeout output reports a slave that has kept ready high too long after the end of a block.

Top module: `spi_rdy_slave`

## Requirements
- R1: After reset, spi_rdy is 0, spi_miso is 0 and rx_done is 0, and the block waits for spi_cs to go high.
- R2: spi_rdy rises in the cycle after the synchronized spi_cs is seen high while idle. Serial clock edges that arrive while no transfer is open (ready low, or chip select already seen low) change no receive or transmit state.
- R3: When cfg_cpol equals cfg_cpha, MOSI is sampled on rising SCLK edges and MISO changes on falling edges; otherwise the roles of the two edges are swapped. When cfg_cpha is 0, the first MISO bit is already valid when spi_rdy rises.
- R4: Every byte is shifted MSB first in both directions. Byte k of the block is held in bits [8*MAX_BYTES-1-8k -: 8] of rx_data and is sent from the same bits of tx_data.
- R5: When chip select falls after a block, rx_done pulses for one cycle and rx_count gives the number of whole bytes received. rx_data and rx_count then stay stable until the next transfer opens.
- R6: If chip select falls in the middle of a byte, the partial bits are dropped and rx_err is 1 in the rx_done cycle. rx_err is 0 after a block that ends on a byte boundary.
- R7: Bytes beyond MAX_BYTES are not stored, rx_count stops at MAX_BYTES, and spi_miso sends 0 for every bit past the end of the status block.
- R8: After chip select falls, spi_rdy stays high until proc_done has been seen after the end of the block and tx_load has been applied since the transfer opened; spi_rdy falls only after both. A proc_done pulse given while idle does not count.
- R9: A tx_load applied while a transfer is open is ignored: the bits being sent do not change, and the load does not count toward R8.
- R10: If spi_rdy is still high FALL_TMO cycles after the end of a block, hs_late pulses once. It does not pulse when the response arrives sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs | input | 1 | Active-high chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_rdy | output | 1 | Handshake line to the master |
| rx_data | output | 8*MAX_BYTES | Received block, byte 0 in the top bits |
| rx_count | output | clog2(MAX_BYTES+1) | Whole bytes received in the last block |
| rx_done | output | 1 | One-cycle strobe at the end of a block |
| rx_err | output | 1 | Block ended with a partial byte (valid with rx_done) |
| tx_data | input | 8*MAX_BYTES | Status block for the next cycle, byte 0 in the top bits |
| tx_load | input | 1 | Captures tx_data while no transfer is open |
| proc_done | input | 1 | Local logic has finished with the received block |
| hs_late | output | 1 | One-cycle pulse when ready is held too long after a block |

## Verification
The assertions assume the master follows the handshake: it does not toggle SCLK before ready is high, it leaves SCLK at its idle level when chip select changes, and it keeps each SCLK level for at least four system clocks so the synchronizers cannot merge or miss edges. The stimulus holds each SCLK level for six system clocks and changes MOSI together with an edge the slave does not sample. Polarity and phase change only while the slave is idle. The only SCLK activity outside an open transfer comes from toggles made while ready is low, and those are there on purpose to test R2.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_XFER = 2'd1,
    HS_PROC = 2'd2
  } hs_state_e;
endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/spi_rdy_shifter.sv
module spi_rdy_shifter #(
  parameter  int MAX_BYTES = 4,
  localparam int BITS      = MAX_BYTES * 8,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int IDX_W     = $clog2(BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             sclk_s,
  input  logic             mosi_s,
  input  logic             en,
  input  logic             start,
  input  logic [BITS-1:0]  tx_flat,
  output logic             miso,
  output logic [BITS-1:0]  rx_flat,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             partial
);
  logic             sclk_q;
  logic [6:0]       sreg_q, sreg_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] out_q, out_d;
  logic             arm_q, arm_d;
  logic             rise, fall, smp_on_rise, smp_edge, drv_edge, wr_en;
  logic             miso_c;

  assign rise        = sclk_s & ~sclk_q;
  assign fall        = ~sclk_s & sclk_q;
  assign smp_on_rise = (cpol == cpha);
  assign smp_edge    = en & (smp_on_rise ? rise : fall);
  assign drv_edge    = en & (smp_on_rise ? fall : rise);
  assign wr_en       = smp_edge & ~start & (bit_q == 3'd7) &
                       (cnt_q < CNT_W'(MAX_BYTES));

  always_comb begin
    sreg_d = sreg_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    arm_d  = arm_q;
    if (start) begin
      bit_d = '0;
      cnt_d = '0;
      out_d = '0;
      arm_d = cpha;
    end else begin
      if (smp_edge) begin
        sreg_d = {sreg_q[5:0], mosi_s};
        bit_d  = bit_q + 3'd1;
        if (wr_en) cnt_d = cnt_q + 1'b1;
      end
      if (drv_edge) begin
        if (arm_q) arm_d = 1'b0;
        else if (out_q < IDX_W'(BITS)) out_d = out_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sreg_q <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sreg_q <= sreg_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      arm_q  <= arm_d;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rx
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else if (wr_en && (cnt_q == CNT_W'(g))) byte_q <= {sreg_q, mosi_s};
    end
    assign rx_flat[BITS-1-8*g -: 8] = byte_q;
  end

  always_comb begin
    miso_c = 1'b0;
    for (int i = 0; i < BITS; i++) begin
      if (out_q == IDX_W'(BITS - 1 - i)) miso_c = tx_flat[i];
    end
  end

  assign miso     = miso_c;
  assign byte_cnt = cnt_q;
  assign partial  = (bit_q != 3'd0);

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_BYTES));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> ($stable(bit_q) && $stable(cnt_q) && $stable(out_q)));
endmodule

// File: rtl/spi_rdy_hs.sv
module spi_rdy_hs
  import spi_rdy_pkg::*;
#(
  parameter  int FALL_TMO = 2_500_000,
  localparam int TMO_W    = $clog2(FALL_TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic proc_done,
  input  logic tx_load,
  input  logic partial,
  output logic rdy,
  output logic xfer,
  output logic start,
  output logic load_ok,
  output logic rx_done,
  output logic rx_err,
  output logic hs_late
);
  hs_state_e        state_q, state_d;
  logic             proc_seen_q, proc_seen_d;
  logic             tx_loaded_q, tx_loaded_d;
  logic             done_q, done_d, err_q, err_d, late_q, late_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             stay_proc;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      HS_IDLE: if (cs_s) begin state_d = HS_XFER; start = 1'b1; end
      HS_XFER: if (!cs_s) state_d = HS_PROC;
      HS_PROC: if (proc_seen_q && tx_loaded_q) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
    stay_proc   = (state_q == HS_PROC) && (state_d == HS_PROC);
    load_ok     = tx_load && (state_q != HS_XFER);
    proc_seen_d = stay_proc && (proc_seen_q || proc_done);
    tx_loaded_d = start ? 1'b0 : (tx_loaded_q || load_ok);
    done_d      = (state_q == HS_XFER) && !cs_s;
    err_d       = done_d && partial;
    if (stay_proc) tmo_d = (tmo_q == TMO_W'(FALL_TMO)) ? tmo_q : tmo_q + 1'b1;
    else           tmo_d = '0;
    late_d      = stay_proc && (tmo_q == TMO_W'(FALL_TMO - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= HS_IDLE;
      proc_seen_q <= 1'b0;
      tx_loaded_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      late_q      <= 1'b0;
      tmo_q       <= '0;
    end else begin
      state_q     <= state_d;
      proc_seen_q <= proc_seen_d;
      tx_loaded_q <= tx_loaded_d;
      done_q      <= done_d;
      err_q       <= err_d;
      late_q      <= late_d;
      tmo_q       <= tmo_d;
    end
  end

  assign rdy     = (state_q != HS_IDLE);
  assign xfer    = (state_q == HS_XFER);
  assign rx_done = done_q;
  assign rx_err  = err_q;
  assign hs_late = late_q;

  // R2
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_IDLE && cs_s) |=> rdy);

  // R8
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(proc_seen_q && tx_loaded_q));

  // R5
  done_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> rdy);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_done);

  // R10
  late_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_late |-> (rdy && !xfer));
endmodule

// File: rtl/spi_rdy_slave.sv
module spi_rdy_slave #(
  parameter  int MAX_BYTES = 4,
  parameter  int FALL_TMO  = 2_500_000,
  localparam int BITS      = MAX_BYTES * 8,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             spi_sclk,
  input  logic             spi_cs,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             spi_rdy,
  output logic [BITS-1:0]  rx_data,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_done,
  output logic             rx_err,
  input  logic [BITS-1:0]  tx_data,
  input  logic             tx_load,
  input  logic             proc_done,
  output logic             hs_late
);
  logic [1:0]      rst_pipe_q;
  logic            rst_int_n;
  logic [2:0]      sync_q;
  logic            sclk_s, cs_s, mosi_s;
  logic [BITS-1:0] tx_q;
  logic            xfer, start, load_ok, partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  spi_rdy_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({spi_sclk, spi_cs, spi_mosi}),
    .q     (sync_q)
  );
  assign {sclk_s, cs_s, mosi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   tx_q <= '0;
    else if (load_ok) tx_q <= tx_data;
  end

  spi_rdy_hs #(.FALL_TMO(FALL_TMO)) u_hs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cs_s      (cs_s),
    .proc_done (proc_done),
    .tx_load   (tx_load),
    .partial   (partial),
    .rdy       (spi_rdy),
    .xfer      (xfer),
    .start     (start),
    .load_ok   (load_ok),
    .rx_done   (rx_done),
    .rx_err    (rx_err),
    .hs_late   (hs_late)
  );

  spi_rdy_shifter #(.MAX_BYTES(MAX_BYTES)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpol     (cfg_cpol),
    .cpha     (cfg_cpha),
    .sclk_s   (sclk_s),
    .mosi_s   (mosi_s),
    .en       (xfer),
    .start    (start),
    .tx_flat  (tx_q),
    .miso     (spi_miso),
    .rx_flat  (rx_data),
    .byte_cnt (rx_count),
    .partial  (partial)
  );

  // R9
  tx_freeze_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer |=> $stable(tx_q));

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!spi_rdy && !rx_done));
endmodule

// File: tb/tb_spi_rdy_slave.sv
`timescale 1ns/1ps
module tb_spi_rdy_slave;
  localparam int MAXB = 4;
  localparam int BITS = MAXB * 8;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int TMO  = 64;
  localparam int HP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic spi_sclk = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_rdy, rx_done, rx_err, hs_late;
  logic [BITS-1:0] rx_data;
  logic [CW-1:0]   rx_count;
  logic [BITS-1:0] tx_data = '0;
  logic tx_load = 1'b0, proc_done = 1'b0;

  int errs = 0, checks = 0;
  int done_n = 0, late_n = 0;
  logic [BITS-1:0] got_rx;
  logic [CW-1:0]   got_cnt;
  logic            got_err;
  logic [7:0]      mbytes [8];

  always #2 clk = ~clk;

  spi_rdy_slave #(.MAX_BYTES(MAXB), .FALL_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sclk(spi_sclk), .spi_cs(spi_cs), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_rdy(spi_rdy), .rx_data(rx_data),
    .rx_count(rx_count), .rx_done(rx_done), .rx_err(rx_err),
    .tx_data(tx_data), .tx_load(tx_load), .proc_done(proc_done),
    .hs_late(hs_late)
  );

  always @(negedge clk) begin
    if (rx_done) begin
      got_rx  <= rx_data;
      got_cnt <= rx_count;
      got_err <= rx_err;
      done_n  <= done_n + 1;
    end
    if (hs_late) late_n <= late_n + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mval(input int t, input int k);
    return 8'((8'h35 * k) + (8'h1D * t) + 8'hA0);
  endfunction

  function automatic logic [7:0] sval(input int t, input int k);
    return 8'((8'hC3 ^ 8'(k * 8'h47)) + 8'(t * 3));
  endfunction

  function automatic logic [BITS-1:0] build_tx(input int t);
    logic [BITS-1:0] f;
    for (int k = 0; k < MAXB; k++) f[BITS-1-8*k -: 8] = sval(t, k);
    return f;
  endfunction

  task automatic pulse_load(input logic [BITS-1:0] d);
    tx_data = d; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic pulse_proc();
    proc_done = 1'b1; @(negedge clk); proc_done = 1'b0;
  endtask

  task automatic run_block(input int t, input int nbytes, input int xbits,
                           input bit pol, input bit pha, input bit midload,
                           input bit slow);
    int total, exn, d0, l0, lim;
    logic [7:0] mv;
    logic mb;
    total = nbytes * 8 + xbits;
    exn = (nbytes > MAXB) ? MAXB : nbytes;
    for (int k = 0; k < 8; k++) mbytes[k] = 8'h00;
    cfg_cpol = pol; cfg_cpha = pha; spi_sclk = pol;
    wait_n(4);
    // R2: edges while ready is low must be ignored
    for (int j = 0; j < 3; j++) begin
      spi_mosi = 1'b1; spi_sclk = ~pol; wait_n(HP); spi_sclk = pol; wait_n(HP);
    end
    if (t % 2 == 1) pulse_proc();  // R8: proc_done while idle does not count
    spi_cs = 1'b1;
    lim = 0;
    while (!spi_rdy && lim < 40) begin @(negedge clk); lim++; end
    chk(spi_rdy == 1'b1, "R2 ready after cs", 32'(spi_rdy), 1);
    for (int i = 0; i < total; i++) begin
      mv = mval(t, i / 8);
      if (!pha) begin
        spi_mosi = mv[7 - (i % 8)]; wait_n(HP); mb = spi_miso;
        spi_sclk = ~pol; wait_n(HP); spi_sclk = pol;
      end else begin
        spi_sclk = ~pol; spi_mosi = mv[7 - (i % 8)]; wait_n(HP); mb = spi_miso;
        spi_sclk = pol; wait_n(HP);
      end
      mbytes[i / 8][7 - (i % 8)] = mb;
      if (midload && i == 8) pulse_load(~build_tx(t));
    end
    wait_n(HP);
    d0 = done_n;
    spi_cs = 1'b0;
    lim = 0;
    while (done_n == d0 && lim < 40) begin @(negedge clk); lim++; end
    chk(done_n == d0 + 1, "R5 done strobe", 32'(done_n - d0), 1);
    chk(got_cnt == CW'(exn), "R5 R7 rx_count", 32'(got_cnt), 32'(exn));
    chk(got_err == (xbits != 0), "R6 rx_err", 32'(got_err), 32'(xbits != 0));
    for (int k = 0; k < exn; k++)
      chk(got_rx[BITS-1-8*k -: 8] == mval(t, k), "R3 R4 rx byte",
          32'(got_rx[BITS-1-8*k -: 8]), 32'(mval(t, k)));
    for (int k = 0; k < nbytes; k++) begin
      if (k < MAXB)
        chk(mbytes[k] == sval(t, k), midload ? "R9 miso byte" : "R3 R4 miso byte",
            32'(mbytes[k]), 32'(sval(t, k)));
      else
        chk(mbytes[k] == 8'h00, "R7 miso past end", 32'(mbytes[k]), 0);
    end
    wait_n(3);
    chk(spi_rdy == 1'b1, "R8 ready held after cs low", 32'(spi_rdy), 1);
    if (slow) begin
      l0 = late_n;
      wait_n(TMO + 16);
      chk(late_n == l0 + 1, "R10 late pulse", 32'(late_n - l0), 1);
      chk(spi_rdy == 1'b1, "R10 ready still high", 32'(spi_rdy), 1);
    end
    if (t % 2 == 0 || midload) begin
      pulse_proc(); wait_n(6);
      chk(spi_rdy == 1'b1, "R8 R9 ready waits for load", 32'(spi_rdy), 1);
      pulse_load(build_tx(t + 1)); wait_n(6);
    end else begin
      pulse_load(build_tx(t + 1)); wait_n(6);
      chk(spi_rdy == 1'b1, "R8 ready waits for proc_done", 32'(spi_rdy), 1);
      pulse_proc(); wait_n(6);
    end
    chk(spi_rdy == 1'b0, "R8 ready falls", 32'(spi_rdy), 0);
    d0 = done_n;
    wait_n(4);
    chk(rx_count == CW'(exn), "R5 count holds", 32'(rx_count), 32'(exn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int t;
    wait_n(3);
    chk(spi_rdy == 1'b0, "R1 ready in reset", 32'(spi_rdy), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(spi_rdy == 1'b0, "R1 ready after reset", 32'(spi_rdy), 0);
    chk(spi_miso == 1'b0, "R1 miso after reset", 32'(spi_miso), 0);
    chk(done_n == 0, "R1 no done after reset", 32'(done_n), 0);
    t = 0;
    pulse_load(build_tx(0));
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= MAXB; n++) begin
        run_block(t, n, 0, m[1], m[0], 1'b0, 1'b0);
        t++;
      end
    end
    chk(late_n == 0, "R10 no late on quick response", 32'(late_n), 0);
    run_block(t, 2, 3, 1'b0, 1'b1, 1'b0, 1'b0); t++;  // R6 partial byte
    run_block(t, 5, 0, 1'b0, 1'b0, 1'b0, 1'b0); t++;  // R7 overflow
    run_block(t, 3, 0, 1'b1, 1'b1, 1'b1, 1'b0); t++;  // R9 load mid-transfer
    run_block(t, 2, 0, 1'b1, 1'b0, 1'b0, 1'b1); t++;  // R10 timeout
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule